// File: doc/BRIEF.md
# Configurable Asynchronous Frame Transmitter

This block turns one parallel character into an asynchronous serial frame. A character enters through a valid/ready handshake. The character length, the parity mode and the stop-bit count all come from a small line-format word. That word is sampled together with the character, so each frame is built from the format that was present when its character was accepted.

Bit timing comes from an oversampling tick input, which is expected at sixteen times the bit rate. Every bit of the frame lasts exactly sixteen ticks. When no frame is in progress the serial line rests high.

A self-test path can fold the serial stream back onto the receive side. When that path is on, the internal line drives the receive-side output and the external transmit pin is held at its resting level. When it is off, the receive-side output simply follows the receive pad.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, `txd` is 1, `busy` is 0 and `tx_ready` is 1.
- R2: A character is accepted on a rising clock edge where `tx_valid` and `tx_ready` are both 1. In the cycle after acceptance, `busy` is 1 and `tx_ready` is 0. While `busy` is 1, `tx_valid` is ignored and the frame in progress is not disturbed.
- R3: A frame opens with one start bit at 0 and closes with its stop bits at 1.
- R4: `line_fmt[1:0]` chooses the number of data bits: encoding 0 gives 5, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits follow the start bit, least significant bit first.
- R5: Every frame bit lasts exactly 16 clock cycles on which `tick16` is 1. The line changes only on the 16th such tick. A tick that arrives in the same cycle as acceptance is not counted.
- R6: `line_fmt[3]`=1 adds a parity bit directly after the data bits. `line_fmt[4]`=1 selects even parity, meaning the count of ones across the data bits plus the parity bit is even. `line_fmt[4]`=0 selects odd parity.
- R7: `line_fmt[2]`=0 sends one stop bit and `line_fmt[2]`=1 sends two.
- R8: The character and the format are captured at acceptance. Changing `tx_data` or `line_fmt` later has no effect on the frame being sent.
- R9: When `loop_en` is 1, `txd` stays at 1 and `rx_core` carries the frame. When `loop_en` is 0, `rx_core` equals `rxd_pad`.
- R10: `busy` falls in the cycle after the 16th tick of the last stop bit. `tx_ready` is 1 from that cycle on, and the line is high between frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling tick, 16 per bit |
| line_fmt | input | 5 | Format word: length, stop count, parity enable, parity sense |
| loop_en | input | 1 | Fold the serial stream back onto `rx_core` |
| tx_valid | input | 1 | Character offered |
| tx_data | input | 8 | Character to send |
| tx_ready | output | 1 | Character can be accepted |
| busy | output | 1 | Frame in progress |
| txd | output | 1 | Serial output pin, idles high |
| rxd_pad | input | 1 | Serial input pin |
| rx_core | output | 1 | Serial input seen by the receive side |

## Verification
Characters are sent with every length code. Parity is tried off, even and odd, and with one or two stop bits. Each waveform is compared cycle by cycle against a frame built independently in the bench, which separates errors in bit order, frame length, parity sense and stop count. The tick is applied both every cycle and every third cycle, and it is also asserted in the acceptance cycle, so that bit timing is shown to follow ticks rather than clock cycles. The bench also changes the format and data inputs mid-frame and offers a second character while busy, to show both are ignored. A loopback frame and a pass-through pad pattern show which path feeds `rx_core`.

// File: rtl/atx_pkg.sv
package atx_pkg;
  localparam int DATA_MAX = 8;
  localparam int FRAME_MAX = 1 + DATA_MAX + 1 + 2;

  typedef struct packed {
    logic par_even;
    logic par_en;
    logic two_stop;
    logic [1:0] len_sel;
  } fmt_t;

  function automatic logic [3:0] data_bits(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction

  function automatic logic parity_of(input logic [DATA_MAX-1:0] d,
                                     input logic [3:0] n,
                                     input logic even);
    logic acc;
    acc = 1'b0;
    for (int i = 0; i < DATA_MAX; i++)
      if (i < int'(n)) acc = acc ^ d[i];
    return even ? acc : ~acc;
  endfunction
endpackage

// File: rtl/atx_frame_pack.sv
module atx_frame_pack
  import atx_pkg::*;
#(
  parameter int FRAME_W = FRAME_MAX,
  parameter int LEN_W = 4
) (
  input  logic [DATA_MAX-1:0] data,
  input  fmt_t                fmt,
  output logic [FRAME_W-1:0]  frame,
  output logic [LEN_W-1:0]    frame_len
);
  logic [3:0] nd;
  logic       par;
  logic [FRAME_W-1:0] data_ext;

  assign nd = data_bits(fmt.len_sel);
  assign par = parity_of(data, nd, fmt.par_even);
  assign data_ext = FRAME_W'(data);

  always_comb begin
    for (int b = 0; b < FRAME_W; b++) begin
      int idx;
      idx = (b == 0) ? 0 : b - 1;
      if (b == 0) frame[b] = 1'b0;
      else if (b <= int'(nd)) frame[b] = data_ext[idx];
      else if (fmt.par_en && b == int'(nd) + 1) frame[b] = par;
      else frame[b] = 1'b1;
    end
    frame_len = LEN_W'(1 + int'(nd) + (fmt.par_en ? 1 : 0) + (fmt.two_stop ? 2 : 1));
  end
endmodule

// File: rtl/atx_tick_div.sv
module atx_tick_div #(
  parameter int OVS = 16,
  localparam int CW = (OVS > 1) ? $clog2(OVS) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  logic [CW-1:0] cnt;
  logic last;

  assign last = (cnt == CW'(OVS - 1));
  assign bit_end = run && tick && last && !clear;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (clear) cnt <= '0;
    else if (run && tick) cnt <= last ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/atx_shifter.sv
module atx_shifter #(
  parameter int FRAME_W = 12,
  parameter int LEN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [FRAME_W-1:0] frame,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic               bit_end,
  output logic               line,
  output logic               busy
);
  logic [FRAME_W-1:0] shreg;
  logic [LEN_W-1:0]   left;

  assign line = busy ? shreg[0] : 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg <= '1;
      left  <= '0;
      busy  <= 1'b0;
    end else if (load) begin
      shreg <= frame;
      left  <= frame_len;
      busy  <= 1'b1;
    end else if (busy && bit_end) begin
      shreg <= {1'b1, shreg[FRAME_W-1:1]};
      left  <= left - 1'b1;
      if (left == LEN_W'(1)) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
  import atx_pkg::*;
#(
  parameter int OVS = 16,
  localparam int FRAME_W = FRAME_MAX,
  localparam int LEN_W = $clog2(FRAME_W + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick16,
  input  logic [4:0]          line_fmt,
  input  logic                loop_en,
  input  logic                tx_valid,
  input  logic [DATA_MAX-1:0] tx_data,
  output logic                tx_ready,
  output logic                busy,
  output logic                txd,
  input  logic                rxd_pad,
  output logic                rx_core
);
  logic               accept;
  logic               bit_end;
  logic               line;
  logic [FRAME_W-1:0] frame;
  logic [LEN_W-1:0]   frame_len;
  fmt_t               fmt;

  assign fmt      = fmt_t'(line_fmt);
  assign tx_ready = !busy;
  assign accept   = tx_valid && tx_ready;

  atx_frame_pack #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_pack (
    .data(tx_data), .fmt(fmt), .frame(frame), .frame_len(frame_len)
  );

  atx_tick_div #(.OVS(OVS)) u_div (
    .clk(clk), .rst_n(rst_n), .clear(accept), .run(busy),
    .tick(tick16), .bit_end(bit_end)
  );

  atx_shifter #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(accept), .frame(frame),
    .frame_len(frame_len), .bit_end(bit_end), .line(line), .busy(busy)
  );

  assign txd     = loop_en ? 1'b1 : line;
  assign rx_core = loop_en ? line : rxd_pad;
endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic tx_ready,
  input logic tx_valid,
  input logic line,
  input logic bit_end
);
  AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> line); // R10
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> !line); // R3
  AST_TAKE_CHAR: assert property (@(posedge clk) disable iff (!rst_n) (tx_valid && tx_ready) |=> (busy && !tx_ready)); // R2
  AST_HOLD_BIT: assert property (@(posedge clk) disable iff (!rst_n) (busy && !bit_end && !(tx_valid && tx_ready)) |=> ($stable(line) && busy)); // R5
  AST_END_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy) |-> $past(bit_end)); // R10
endmodule

bind async_frame_tx async_frame_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .tx_ready(tx_ready),
  .tx_valid(tx_valid), .line(line), .bit_end(bit_end)
);

// File: tb/async_frame_tx_test.sv
module async_frame_tx_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick16 = 1'b0;
  logic [4:0] line_fmt = 5'd3;
  logic loop_en = 1'b0;
  logic tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic tx_ready, busy, txd, rx_core;
  logic rxd_pad = 1'b1;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  async_frame_tx uut (
    .clk(clk), .rst_n(rst_n), .tick16(tick16), .line_fmt(line_fmt),
    .loop_en(loop_en), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .busy(busy), .txd(txd), .rxd_pad(rxd_pad),
    .rx_core(rx_core)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer than 150000", cycles);
      report();
    end
  end

  task automatic chk(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b at %0t", what, act, exp, $time);
    end
  endtask

  // Expected frame assembled bit by bit from the requirement text.
  function automatic void expect_frame(input logic [7:0] d, input logic [4:0] f,
                                       output logic [15:0] bits, output int n);
    int nd, ones;
    bits = '1;
    n = 0;
    ones = 0;
    bits[n] = 1'b0; n++;                        // R3 start
    nd = 5 + int'(f[1:0]);                      // R4 length
    for (int k = 0; k < nd; k++) begin
      bits[n] = d[k]; n++;
      if (d[k]) ones++;
    end
    if (f[3]) begin                             // R6 parity
      bits[n] = f[4] ? ((ones % 2) == 1) : ((ones % 2) == 0);
      n++;
    end
    bits[n] = 1'b1; n++;                        // R7 stops
    if (f[2]) begin bits[n] = 1'b1; n++; end
  endfunction

  task automatic send(input logic [7:0] d, input logic [4:0] f, input int per,
                      input logic loop, input string tag);
    logic [15:0] bits;
    int n, ticks, phase, idx;
    bit poked;
    expect_frame(d, f, bits, n);
    @(negedge clk);
    loop_en = loop;
    chk(tx_ready, 1'b1, {tag, " R2 ready before offer"});
    tx_valid = 1'b1; tx_data = d; line_fmt = f;
    tick16 = 1'b1;                              // R5 tick at accept is not counted
    @(posedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
    tx_data = ~d; line_fmt = ~f;                // R8 later changes ignored
    ticks = 0; phase = 0; poked = 0;
    forever begin
      idx = ticks / 16;
      if (idx < n) begin
        chk(busy, 1'b1, {tag, " R2 busy"});
        chk(tx_ready, 1'b0, {tag, " R2 ready low"});
        if (loop) begin
          chk(rx_core, bits[idx], {tag, " R9 loop bit"});
          chk(txd, 1'b1, {tag, " R9 pin held"});
        end else
          chk(txd, bits[idx], {tag, " R3/R4/R5/R6/R7 bit"});
      end else begin
        chk(busy, 1'b0, {tag, " R10 busy fall"});
        chk(tx_ready, 1'b1, {tag, " R10 ready"});
        chk(txd, 1'b1, {tag, " R10 idle"});
        break;
      end
      phase++;
      tick16 = ((phase % per) == 0);
      if (!poked && ticks == 40) begin
        tx_valid = 1'b1;                        // R2 offer while busy
        poked = 1;
      end
      @(posedge clk);
      if (tick16) ticks++;
      @(negedge clk);
      tx_valid = 1'b0;
    end
    tick16 = 1'b0;
    loop_en = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(txd, 1'b1, "R1 txd");
    chk(busy, 1'b0, "R1 busy");
    chk(tx_ready, 1'b1, "R1 ready");
  endtask

  task automatic t_pass_through();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      rxd_pad = i[0];
      #1;
      chk(rx_core, i[0], "R9 pad pass-through");
    end
    rxd_pad = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    send(8'hA5, 5'b00011, 1, 1'b0, "8N1");
    send(8'h13, 5'b11000, 1, 1'b0, "5E1");
    send(8'h6E, 5'b01110, 3, 1'b0, "7O2");
    send(8'hFF, 5'b11101, 1, 1'b0, "6E2");
    send(8'h2C, 5'b00111, 3, 1'b0, "8N2");
    send(8'h5A, 5'b01011, 1, 1'b1, "loop8O1");
    t_pass_through();
    report();
  end
endmodule